// File: doc/BRIEF.md
# GPIO port interrupt detector

This block watches the 32 input pins of one general-purpose I/O port and turns selected pin activity into a single interrupt request for the system interrupt controller. Each pin has its own 2-bit trigger mode. The four modes are rising edge, falling edge, high level and low level. A pin takes part only when it is enabled for general-purpose use and its direction is set to input.

Pin values pass through a two-flop synchroniser. Edges are detected by comparing the synchronised value with the value from one clock earlier. Detected events set sticky pending bits. Software clears a pending bit by writing a one to its position in the status register. A per-pin mask selects which pending bits can reach the output. Status bits keep latching events even while their mask bit is 0.

The output is driven by a two-state line machine:
- State `LINE_QUIET`: the line is low.
- State `LINE_RAISED`: the line is high.
- Transition *raise* (QUIET to RAISED): taken on the clock after any pin is both pending and unmasked.
- Transition *drop* (RAISED to QUIET): taken on the clock after no pin is both pending and unmasked any longer.
- Transitions *hold-quiet* and *hold-raised*: the state stays the same otherwise.

Software reaches every register through a 32-bit write port and a combinational read port that share one address.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads as zero and `port_irq` is low. This leaves all pins masked, in rising-edge mode, not enabled and set to input.
- R2: The register addresses are as follows.
  - 0x00: trigger modes of pins 0..15.
  - 0x04: trigger modes of pins 16..31.
  - 0x08: mask.
  - 0x0C: status.
  - 0x10: use-enable.
  - 0x14: direction, where 0 means input.
  Pin p's mode field occupies bits [2*(p mod 16)+1 : 2*(p mod 16)] of its mode register. Written values read back unchanged.
- R3: Mode 00 (rising edge) sets the pin's status bit on a 0-to-1 transition of the pin and does not set it on a 1-to-0 transition.
- R4: Mode 01 (falling edge) sets the pin's status bit on a 1-to-0 transition of the pin and does not set it on a 0-to-1 transition.
- R5: Mode 10 (high level) sets the status bit on every clock while the synchronised pin is 1. Mode 11 (low level) does the same while the synchronised pin is 0.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A set status bit stays set until it is cleared this way.
- R7: When a detected event and a write-one clear hit the same status bit in the same cycle, the bit stays set. A level-mode pin therefore cannot be cleared while its level persists.
- R8: `port_irq` is the registered OR of (status AND mask). Status bits still latch events while their mask bit is 0.
- R9: A pin whose use-enable bit is 0, or whose direction bit is 1, never sets its status bit.
- R10: Suppose a pin changes between two clock edges. Its status bit reads as set after the third following edge and not after the second. `port_irq` rises after the fourth edge when the pin is unmasked.
- R11: A mask or status write that changes whether any unmasked pin is pending changes `port_irq` exactly one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register addressed by `bus_addr` |
| bus_addr | input | 5 | Register byte address, used for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| pin_in | input | 32 | Asynchronous port pin values |
| port_irq | output | 1 | Aggregated port interrupt request |

## Verification
A wrong pending bit appears in the status read three edges after the pin change that caused it. It also appears on `port_irq` one edge later, if the pin is unmasked. A stuck or lost line-machine state shows on `port_irq` on the clock after a mask or status write, so the bench samples that line at both the write edge and the edge after it. A misplaced mode field shows as the wrong pin, or the wrong polarity, setting a status bit. The bench probes this with fields in both mode registers and with neighbouring pins in different modes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_LOW  = 2'b11
    } trig_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_e;

    localparam logic [4:0] OFS_MODE_LO = 5'h00;
    localparam logic [4:0] OFS_MODE_HI = 5'h04;
    localparam logic [4:0] OFS_MASK    = 5'h08;
    localparam logic [4:0] OFS_STATUS  = 5'h0C;
    localparam logic [4:0] OFS_USE     = 5'h10;
    localparam logic [4:0] OFS_DIR     = 5'h14;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  cur,
    input  logic [DATA_W-1:0] mode_lo,
    input  logic [DATA_W-1:0] mode_hi,
    input  logic [NPINS-1:0]  use_en,
    input  logic [NPINS-1:0]  dir_out,
    output logic [NPINS-1:0]  evt
);
    localparam int FIELDS = DATA_W / 2;

    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int REG_SEL = p / FIELDS;
        localparam int SLOT    = p % FIELDS;
        trig_e mode;
        logic  hit;

        if (REG_SEL == 0) begin : g_lo
            assign mode = trig_e'(mode_lo[2*SLOT +: 2]);
        end else begin : g_hi
            assign mode = trig_e'(mode_hi[2*SLOT +: 2]);
        end

        always_comb begin
            unique case (mode)
                TRIG_RISE: hit = cur[p] & ~prev_q[p];
                TRIG_FALL: hit = ~cur[p] & prev_q[p];
                TRIG_HIGH: hit = cur[p];
                TRIG_LOW:  hit = ~cur[p];
            endcase
        end

        assign evt[p] = hit & use_en[p] & ~dir_out[p];
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  evt,
    output logic [DATA_W-1:0] mode_lo,
    output logic [DATA_W-1:0] mode_hi,
    output logic [NPINS-1:0]  mask,
    output logic [NPINS-1:0]  status,
    output logic [NPINS-1:0]  use_en,
    output logic [NPINS-1:0]  dir_out
);
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] status_nxt;

    always_comb begin
        clr_vec    = (bus_wr && bus_addr == OFS_STATUS) ? bus_wdata[NPINS-1:0] : '0;
        status_nxt = (status & ~clr_vec) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_lo <= '0;
            mode_hi <= '0;
            mask    <= '0;
            use_en  <= '0;
            dir_out <= '0;
            status  <= '0;
        end else begin
            status <= status_nxt;
            if (bus_wr) begin
                case (bus_addr)
                    OFS_MODE_LO: mode_lo <= bus_wdata;
                    OFS_MODE_HI: mode_hi <= bus_wdata;
                    OFS_MASK:    mask    <= bus_wdata[NPINS-1:0];
                    OFS_USE:     use_en  <= bus_wdata[NPINS-1:0];
                    OFS_DIR:     dir_out <= bus_wdata[NPINS-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE_LO: bus_rdata = mode_lo;
            OFS_MODE_HI: bus_rdata = mode_hi;
            OFS_MASK:    bus_rdata[NPINS-1:0] = mask;
            OFS_STATUS:  bus_rdata[NPINS-1:0] = status;
            OFS_USE:     bus_rdata[NPINS-1:0] = use_en;
            OFS_DIR:     bus_rdata[NPINS-1:0] = dir_out;
            default:     bus_rdata = '0;
        endcase
    end

    // R6: bits written as 1 with no event that cycle are clear afterwards
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STATUS)
        |=> ((status & $past(bus_wdata[NPINS-1:0] & ~evt)) == '0));

    // R7: a detected event always leaves its bit set, even against a clear
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(evt)) == $past(evt)));

    // R6: a set bit only drops when written with a one
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr_vec) & ~status) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic              port_irq
);
    logic [NPINS-1:0]  pin_sync;
    logic [NPINS-1:0]  evt;
    logic [DATA_W-1:0] mode_lo;
    logic [DATA_W-1:0] mode_hi;
    logic [NPINS-1:0]  mask;
    logic [NPINS-1:0]  status;
    logic [NPINS-1:0]  use_en;
    logic [NPINS-1:0]  dir_out;
    logic              any_live;
    line_e             state_q;
    line_e             state_d;

    gpio_irq_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_irq_detect #(.NPINS(NPINS), .DATA_W(DATA_W)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (pin_sync),
        .mode_lo (mode_lo),
        .mode_hi (mode_hi),
        .use_en  (use_en),
        .dir_out (dir_out),
        .evt     (evt)
    );

    gpio_irq_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt),
        .mode_lo   (mode_lo),
        .mode_hi   (mode_hi),
        .mask      (mask),
        .status    (status),
        .use_en    (use_en),
        .dir_out   (dir_out)
    );

    assign any_live = |(status & mask);

    always_comb begin
        unique case (state_q)
            LINE_QUIET:  state_d = any_live ? LINE_RAISED : LINE_QUIET;
            LINE_RAISED: state_d = any_live ? LINE_RAISED : LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        port_irq = (state_q == LINE_RAISED);
    end

    // R8, R11: the line follows the masked pending set one clock later
    p_line_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (port_irq == $past(|(status & mask))));

    // R9: a disabled or output pin never raises its status bit
    p_ineligible_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ($past(~use_en) | $past(dir_out))) == '0));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_MLO  = 5'h00;
    localparam logic [4:0] A_MHI  = 5'h04;
    localparam logic [4:0] A_MASK = 5'h08;
    localparam logic [4:0] A_STAT = 5'h0C;
    localparam logic [4:0] A_USE  = 5'h10;
    localparam logic [4:0] A_DIR  = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '0;
    logic        port_irq;
    int          total = 0;
    int          bad = 0;

    gpio_irq_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pins),
        .port_irq  (port_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pins[p] = v;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_MLO, d);  chk("R1 mode_lo", d, 0);
        rd(A_MHI, d);  chk("R1 mode_hi", d, 0);
        rd(A_MASK, d); chk("R1 mask", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd(A_USE, d);  chk("R1 use", d, 0);
        rd(A_DIR, d);  chk("R1 dir", d, 0);
        chk("R1 irq", {31'b0, port_irq}, 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(A_MLO, 32'hA5A5_0F0F); rd(A_MLO, d); chk("R2 mode_lo readback", d, 32'hA5A5_0F0F);
        wr(A_MHI, 32'h1234_5678); rd(A_MHI, d); chk("R2 mode_hi readback", d, 32'h1234_5678);
        wr(A_DIR, 32'hFFFF_0000); rd(A_DIR, d); chk("R2 dir readback", d, 32'hFFFF_0000);
        wr(A_MLO, 0); wr(A_MHI, 0); wr(A_DIR, 0);
        wr(A_USE, 32'hFFFF_FFFF); rd(A_USE, d); chk("R2 use readback", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_rise;
        logic [31:0] d;
        set_pin(3, 1); edges(4);
        rd(A_STAT, d); chk("R3 rising sets", d, 32'h8);
        wr(A_STAT, 32'h8); rd(A_STAT, d); chk("R6 clear", d, 0);
        set_pin(3, 0); edges(4);
        rd(A_STAT, d); chk("R3 falling ignored", d, 0);
    endtask

    task automatic t_fall;
        logic [31:0] d;
        wr(A_MHI, 32'h0000_0004);
        set_pin(17, 1); edges(4);
        rd(A_STAT, d); chk("R4 rise ignored in fall mode", d, 0);
        set_pin(17, 0); edges(4);
        rd(A_STAT, d); chk("R4 R2 falling pin17", d, 32'h0002_0000);
        wr(A_STAT, 32'hFFFF_FFFF); wr(A_MHI, 0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        @(negedge clk); pins[0] = 1; pins[1] = 1;
        edges(4);
        rd(A_STAT, d); chk("R3 two pins", d, 32'h3);
        wr(A_STAT, 32'h1); rd(A_STAT, d); chk("R6 partial clear", d, 32'h2);
        wr(A_STAT, 32'h0); rd(A_STAT, d); chk("R6 zero write keeps", d, 32'h2);
        edges(3);          rd(A_STAT, d); chk("R6 sticky", d, 32'h2);
        wr(A_STAT, 32'h2); rd(A_STAT, d); chk("R6 final clear", d, 0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(A_MLO, 32'h0000_0800);
        set_pin(5, 1); edges(4);
        rd(A_STAT, d); chk("R5 high level", d, 32'h20);
        wr(A_STAT, 32'h20); rd(A_STAT, d); chk("R7 clear loses to level", d, 32'h20);
        set_pin(5, 0); edges(4);
        wr(A_STAT, 32'h20); rd(A_STAT, d); chk("R7 clear after level gone", d, 0);
        wr(A_MLO, 32'h0000_3800); edges(1);
        rd(A_STAT, d); chk("R5 low level pin6", d, 32'h40);
        set_pin(6, 1); edges(4);
        wr(A_STAT, 32'h40); rd(A_STAT, d); chk("R5 low level released", d, 0);
        wr(A_MLO, 0); wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        set_pin(9, 1); edges(4);
        rd(A_STAT, d); chk("R8 latched while masked", d, 32'h200);
        chk("R8 masked line low", {31'b0, port_irq}, 0);
        wr(A_MASK, 32'h200);
        chk("R11 not yet raised", {31'b0, port_irq}, 0);
        edges(1); chk("R11 raise", {31'b0, port_irq}, 1);
        wr(A_STAT, 32'h200);
        chk("R11 still raised", {31'b0, port_irq}, 1);
        edges(1); chk("R11 drop", {31'b0, port_irq}, 0);
    endtask

    task automatic t_latency;
        logic [31:0] d;
        wr(A_MASK, 32'h400);
        set_pin(10, 1);
        edges(1); rd(A_STAT, d); chk("R10 edge1", d, 0);
        edges(1); rd(A_STAT, d); chk("R10 edge2", d, 0);
        edges(1); rd(A_STAT, d); chk("R10 edge3 status", d, 32'h400);
        chk("R10 edge3 line low", {31'b0, port_irq}, 0);
        edges(1); chk("R10 edge4 line high", {31'b0, port_irq}, 1);
        wr(A_STAT, 32'h400); edges(1);
        chk("R10 line cleared", {31'b0, port_irq}, 0);
    endtask

    task automatic t_elig;
        logic [31:0] d;
        wr(A_USE, 32'hFFFF_EFFF);
        set_pin(12, 1); edges(4);
        rd(A_STAT, d); chk("R9 use disabled", d, 0);
        wr(A_DIR, 32'h0000_2000);
        set_pin(13, 1); edges(4);
        rd(A_STAT, d); chk("R9 output pin", d, 0);
        wr(A_USE, 32'hFFFF_FFFF); wr(A_DIR, 0);
        set_pin(14, 1); edges(4);
        rd(A_STAT, d); chk("R9 eligible pin", d, 32'h4000);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_map();
        t_rise();
        t_fall();
        t_w1c();
        t_level();
        t_mask();
        t_latency();
        t_elig();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule